// File: doc/BRIEF.md
# Serial-Bus Target with Port Register Bank

This block is a two-wire serial-bus target (I2C and SMBus compatible) that lets a bus host reach a small bank of eight-bit port registers. It runs on the system clock and treats SCL and SDA as plain asynchronous inputs. Each line passes through a two-flop synchroniser and a glitch filter whose length is set in system clock cycles. Only the filtered lines are used to find SCL edges, START, repeated START and STOP. The target answers a 7-bit address. The low three bits of that address come from strap inputs, so eight copies can share one bus. The upper four bits are a build parameter, so a second build with a different fixed part can sit on the same bus. The target pulls SDA low through an open-drain style enable.

In a write transaction, the first data byte after the address is a command byte. It sets a pointer that persists across transactions. Every later data byte in the same transaction is written to the register the pointer selects. A read transaction returns the selected register, most significant bit first. The register is captured once per byte for as long as the host acknowledges. The bank holds an output-value register, a polarity mask, a direction register and a read-only input view. The input view is the synchronised pins XORed with the polarity mask.

Top module: `i2c_port_target`

## Requirements
- R1: After reset, `drive_o` is 8'hFF, `dir_in_o` is 8'hFF (all pins inputs), the polarity mask is 8'h00 and `sda_pull_o` is 0.
- R2: The target acknowledges only the 7-bit address {ADDR_FIXED (default 4'b0100) in bits 6:3, `strap_i` in bits 2:0}. The address byte on the bus is that address shifted left by one, with bit 0 set to 1 for a read. A non-matching address gets no acknowledge and changes no register.
- R3: In a write transaction, the first data byte sets the pointer from its two low bits: 0 = input view, 1 = output value, 2 = polarity mask, 3 = direction. Each further data byte is acknowledged and written to that register. The pointer does not advance, and it keeps its value into later transactions.
- R4: In a read transaction, the target sends the selected register MSB first. The input view reads as pins XOR polarity. The target reloads the same register while the host acknowledges, and it releases SDA for the host's acknowledge bit, so a host NACK leaves SDA free.
- R5: A data byte written with the pointer at 0 (input view) changes none of the registers.
- R6: A START or repeated START, including one in the middle of a byte, drops the partial byte without writing it and restarts address reception.
- R7: A STOP returns the target to idle with SDA released.
- R8: A low pulse shorter than FILT_CYC system clock cycles (default 5) on SCL or SDA has no effect on the transfer.
- R9: The write pulse `wr_pulse_o` is high for one cycle for each data byte after the command byte. The read pulse `rd_pulse_o` is high for one cycle for each byte loaded for transmission. The two pulses never occur in the same cycle.
- R10: The target starts pulling SDA only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 leaves it released |
| strap_i | input | 3 | Low three address bits from strap pins |
| pins_i | input | 8 | Port pin levels for the input view |
| drive_o | output | 8 | Output-value register |
| dir_in_o | output | 8 | Direction register, 1 = pin is an input |
| wr_pulse_o | output | 1 | One-cycle pulse per register write byte |
| rd_pulse_o | output | 1 | One-cycle pulse per byte loaded for reading |

## Verification
The bench aborts a command byte half way with a repeated START. A design that kept the partial byte would corrupt the pointer or the output register. It drives an address that differs from the straps in one bit and expects no acknowledge and no register change; a wrong compare would act on another target's traffic. Short low pulses are injected on SCL and on SDA (the SDA pulse lands during SCL high, where a missed filter would see a false START) in the middle of data bits. A weak filter would then shift an extra bit in or reset the transfer. Multi-byte reads and writes check that the pointer stays fixed and that exactly one pulse is issued per byte. Random strap, pin, register and value choices are checked against a bench model of the bank.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int unsigned ADDR_W  = 7;
  localparam int unsigned STRAP_W = 3;
  localparam int unsigned FIX_W   = ADDR_W - STRAP_W;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned PTR_W   = 2;

  localparam logic [PTR_W-1:0] SEL_INPUT  = 2'd0;
  localparam logic [PTR_W-1:0] SEL_OUTPUT = 2'd1;
  localparam logic [PTR_W-1:0] SEL_POLAR  = 2'd2;
  localparam logic [PTR_W-1:0] SEL_DIR    = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2ct_line_filter.sv
module i2ct_line_filter #(
  parameter int unsigned FILT_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;

  logic          sync1_q, sync2_q, filt_q, filt_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    filt_d = filt_q;
    cnt_d  = cnt_q;
    if (sync2_q == filt_q) begin
      cnt_d = '0;
    end else if (cnt_q == CW'(FILT_CYC - 1)) begin
      filt_d = sync2_q;
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      filt_q  <= 1'b1;
      cnt_q   <= '0;
    end else begin
      sync1_q <= line_i;
      sync2_q <= sync1_q;
      filt_q  <= filt_d;
      cnt_q   <= cnt_d;
    end
  end

  assign line_o = filt_q;

  // R8: the filtered level only moves to a level the synchroniser was holding
  assert_filt_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(sync2_q) == filt_q));
  // R8: agreement between input and output keeps the output steady
  assert_filt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync2_q == filt_q) |=> (filt_q == $past(filt_q)));
endmodule

// File: rtl/i2ct_bus_events.sv
module i2ct_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_comb begin
    scl_rise  = scl_f & ~scl_q;
    scl_fall  = ~scl_f & scl_q;
    start_det = scl_f & scl_q & sda_q & ~sda_f;
    stop_det  = scl_f & scl_q & ~sda_q & sda_f;
  end
endmodule

// File: rtl/i2ct_target_fsm.sv
module i2ct_target_fsm import i2ct_pkg::*; #(
  parameter logic [FIX_W-1:0] ADDR_FIXED = 4'b0100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_f,
  input  logic               sda_f,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [DATA_W-1:0]  rd_data_i,
  output logic               sda_pull_o,
  output logic               wr_stb_o,
  output logic [DATA_W-1:0]  wr_data_o,
  output logic               rd_stb_o,
  output logic [PTR_W-1:0]   ptr_o
);
  localparam logic [3:0] LAST_BIT = 4'(DATA_W);

  tgt_state_e        st_q, st_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic              rw_q, rw_d, first_q, first_d, mack_q, mack_d;
  logic              oe_q, oe_d, wr_q, wr_d, rd_q, rd_d;
  logic              addr_hit;

  assign addr_hit = (sh_q[DATA_W-1:1] == {ADDR_FIXED, strap_i});

  always_comb begin
    st_d = st_q;  cnt_d = cnt_q;  sh_d = sh_q;  ptr_d = ptr_q;
    rw_d = rw_q;  first_d = first_q;  mack_d = mack_q;  oe_d = oe_q;
    wr_d = 1'b0;  rd_d = 1'b0;
    if (start_det) begin
      st_d  = ST_ADDR;
      cnt_d = '0;
      oe_d  = 1'b0;
    end else if (stop_det) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: ;
        ST_ADDR: begin
          if (scl_rise && cnt_q != LAST_BIT) begin
            sh_d  = {sh_q[DATA_W-2:0], sda_f};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == LAST_BIT) begin
            if (addr_hit) begin
              st_d = ST_ADDR_ACK;
              oe_d = 1'b1;
              rw_d = sh_q[0];
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              st_d = ST_RD;
              sh_d = rd_data_i;
              rd_d = 1'b1;
              oe_d = ~rd_data_i[DATA_W-1];
            end else begin
              st_d    = ST_WR;
              first_d = 1'b1;
              oe_d    = 1'b0;
            end
          end
        end
        ST_WR: begin
          if (scl_rise && cnt_q != LAST_BIT) begin
            sh_d  = {sh_q[DATA_W-2:0], sda_f};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == LAST_BIT) begin
            st_d = ST_WR_ACK;
            oe_d = 1'b1;
            if (first_q) begin
              ptr_d   = sh_q[PTR_W-1:0];
              first_d = 1'b0;
            end else begin
              wr_d = 1'b1;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            st_d  = ST_WR;
            cnt_d = '0;
            oe_d  = 1'b0;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt_q == LAST_BIT - 4'd1) begin
              st_d  = ST_RD_ACK;
              cnt_d = '0;
              oe_d  = 1'b0;
            end else begin
              sh_d  = {sh_q[DATA_W-2:0], 1'b0};
              cnt_d = cnt_q + 4'd1;
              oe_d  = ~sh_q[DATA_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack_d = ~sda_f;
          end else if (scl_fall) begin
            if (mack_q) begin
              st_d = ST_RD;
              sh_d = rd_data_i;
              rd_d = 1'b1;
              oe_d = ~rd_data_i[DATA_W-1];
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  cnt_q <= '0;  sh_q <= '0;  ptr_q <= SEL_INPUT;
      rw_q <= 1'b0;  first_q <= 1'b0;  mack_q <= 1'b0;
      oe_q <= 1'b0;  wr_q <= 1'b0;  rd_q <= 1'b0;
    end else begin
      st_q <= st_d;  cnt_q <= cnt_d;  sh_q <= sh_d;  ptr_q <= ptr_d;
      rw_q <= rw_d;  first_q <= first_d;  mack_q <= mack_d;
      oe_q <= oe_d;  wr_q <= wr_d;  rd_q <= rd_d;
    end
  end

  assign sda_pull_o = oe_q;
  assign wr_stb_o   = wr_q;
  assign wr_data_o  = sh_q;
  assign rd_stb_o   = rd_q;
  assign ptr_o      = ptr_q;

  // R10: pulling SDA begins only while the clock line is low
  assert_pull_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && !$past(oe_q)) |-> !scl_f);
  // R7: a STOP leaves the target idle with SDA free
  assert_stop_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st_q == ST_IDLE && !oe_q));
  // R6: a START always restarts address reception from bit zero
  assert_start_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st_q == ST_ADDR && cnt_q == 4'd0));
  // R9: the two strobes never coincide
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_q, rd_q}));
  // R9: a write strobe lasts one cycle
  assert_wr_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |=> !wr_q);
endmodule

// File: rtl/i2ct_reg_bank.sv
module i2ct_reg_bank import i2ct_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] pins_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] drive_o,
  output logic [DATA_W-1:0] dir_in_o
);
  logic [DATA_W-1:0] out_q, pol_q, dir_q, pin1_q, pin2_q;
  logic              out_en, pol_en, dir_en;

  always_comb begin
    out_en = wr_stb_i && (sel_i == SEL_OUTPUT);
    pol_en = wr_stb_i && (sel_i == SEL_POLAR);
    dir_en = wr_stb_i && (sel_i == SEL_DIR);
    unique case (sel_i)
      SEL_OUTPUT: rd_data_o = out_q;
      SEL_POLAR:  rd_data_o = pol_q;
      SEL_DIR:    rd_data_o = dir_q;
      default:    rd_data_o = pin2_q ^ pol_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '1;
      pol_q  <= '0;
      dir_q  <= '1;
      pin1_q <= '0;
      pin2_q <= '0;
    end else begin
      pin1_q <= pins_i;
      pin2_q <= pin1_q;
      if (out_en) out_q <= wr_data_i;
      if (pol_en) pol_q <= wr_data_i;
      if (dir_en) dir_q <= wr_data_i;
    end
  end

  assign drive_o  = out_q;
  assign dir_in_o = dir_q;

  // R5: a write aimed at the input view leaves every register as it was
  assert_input_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb_i && sel_i == SEL_INPUT) |=>
      (out_q == $past(out_q) && pol_q == $past(pol_q) && dir_q == $past(dir_q)));
endmodule

// File: rtl/i2c_port_target.sv
module i2c_port_target import i2ct_pkg::*; #(
  parameter int unsigned      FILT_CYC   = 5,
  parameter logic [FIX_W-1:0] ADDR_FIXED = 4'b0100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [DATA_W-1:0]  pins_i,
  output logic [DATA_W-1:0]  drive_o,
  output logic [DATA_W-1:0]  dir_in_o,
  output logic               wr_pulse_o,
  output logic               rd_pulse_o
);
  localparam int unsigned N_LINES = 2;

  logic                rst_a_q, rst_s_q;
  logic [N_LINES-1:0]  raw, filt;
  logic                scl_rise, scl_fall, start_det, stop_det;
  logic [DATA_W-1:0]   wr_data, rd_data;
  logic [PTR_W-1:0]    ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_a_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_a_q <= 1'b1;
      rst_s_q <= rst_a_q;
    end
  end

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2ct_line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk(clk), .rst_n(rst_s_q), .line_i(raw[g]), .line_o(filt[g])
    );
  end

  i2ct_bus_events u_evt (
    .clk(clk), .rst_n(rst_s_q), .scl_f(filt[0]), .sda_f(filt[1]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2ct_target_fsm #(.ADDR_FIXED(ADDR_FIXED)) u_fsm (
    .clk(clk), .rst_n(rst_s_q), .scl_f(filt[0]), .sda_f(filt[1]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .strap_i(strap_i), .rd_data_i(rd_data), .sda_pull_o(sda_pull_o),
    .wr_stb_o(wr_pulse_o), .wr_data_o(wr_data), .rd_stb_o(rd_pulse_o),
    .ptr_o(ptr)
  );

  i2ct_reg_bank u_bank (
    .clk(clk), .rst_n(rst_s_q), .wr_stb_i(wr_pulse_o), .wr_data_i(wr_data),
    .sel_i(ptr), .pins_i(pins_i), .rd_data_o(rd_data),
    .drive_o(drive_o), .dir_in_o(dir_in_o)
  );
endmodule

// File: tb/i2c_port_target_tb.sv
module i2c_port_target_tb;
  localparam int Q = 20;
  localparam logic [3:0] FIXED = 4'b0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, scl_gl = 1'b0, sda_gl = 1'b0;
  logic sda_pull, wr_p, rd_p;
  logic [2:0] strap = 3'b101;
  logic [7:0] pins = 8'h00, drive, dir_in;
  logic sda_bus, scl_in, sda_in;
  int checks = 0, fails = 0, wr_cnt = 0, rd_cnt = 0, gmode = 0;
  logic [7:0] m_out = 8'hFF, m_pol = 8'h00, m_dir = 8'hFF;

  always #5 clk = ~clk;

  assign sda_bus = sda_pull ? 1'b0 : m_sda;
  assign sda_in  = sda_bus & ~sda_gl;
  assign scl_in  = m_scl & ~scl_gl;

  i2c_port_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_in), .sda_i(sda_in),
    .sda_pull_o(sda_pull), .strap_i(strap), .pins_i(pins),
    .drive_o(drive), .dir_in_o(dir_in), .wr_pulse_o(wr_p), .rd_pulse_o(rd_p)
  );

  always @(posedge clk) begin
    if (wr_p) wr_cnt <= wr_cnt + 1;
    if (rd_p) rd_cnt <= rd_cnt + 1;
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wcyc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] rd_model(logic [1:0] sel);
    case (sel)
      2'd1: return m_out;
      2'd2: return m_pol;
      2'd3: return m_dir;
      default: return pins ^ m_pol;
    endcase
  endfunction

  function automatic void wr_model(logic [1:0] sel, logic [7:0] v);
    case (sel)
      2'd1: m_out = v;
      2'd2: m_pol = v;
      2'd3: m_dir = v;
      default: ;
    endcase
  endfunction

  task automatic bus_start();
    m_sda = 1'b1; wcyc(Q); m_scl = 1'b1; wcyc(Q);
    m_sda = 1'b0; wcyc(Q); m_scl = 1'b0; wcyc(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wcyc(Q); m_scl = 1'b1; wcyc(Q); m_sda = 1'b1; wcyc(Q);
  endtask

  task automatic send_bit(logic b);
    m_sda = b; wcyc(Q); m_scl = 1'b1; wcyc(8);
    if (gmode == 1) begin scl_gl = 1'b1; wcyc(3); scl_gl = 1'b0; end
    else if (gmode == 2 && b) begin sda_gl = 1'b1; wcyc(3); sda_gl = 1'b0; end
    else wcyc(3);
    wcyc(2*Q - 11); m_scl = 1'b0; wcyc(Q);
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; wcyc(Q); m_scl = 1'b1; wcyc(Q);
    b = sda_bus; wcyc(Q); m_scl = 1'b0; wcyc(Q);
  endtask

  task automatic send_byte(logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(logic give_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
    send_bit(~give_ack);
  endtask

  function automatic logic [7:0] abyte(logic [2:0] s, logic rd);
    return {FIXED, s, rd};
  endfunction

  task automatic wr_reg(logic [1:0] sel, logic [7:0] v, output logic ok);
    logic a0, a1, a2;
    bus_start(); send_byte(abyte(strap, 1'b0), a0);
    send_byte({6'd0, sel}, a1); send_byte(v, a2); bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic rd_reg(logic [1:0] sel, output logic [7:0] v);
    logic a;
    bus_start(); send_byte(abyte(strap, 1'b0), a); send_byte({6'd0, sel}, a);
    bus_start(); send_byte(abyte(strap, 1'b1), a);
    recv_byte(1'b0, v); bus_stop();
  endtask

  initial begin
    logic ok, a;
    logic [7:0] v, v2;
    int w0, r0;
    void'($urandom(32'h1C2D));
    wcyc(5); rst_n = 1'b1; wcyc(10);

    // R1 reset state
    chk("R1 drive", drive, 8'hFF);
    chk("R1 dir", dir_in, 8'hFF);
    chk("R1 sda", sda_pull, 1'b0);
    rd_reg(2'd2, v); chk("R1 polarity", v, 8'h00);

    // R2/R3 matching address writes the output register
    wr_reg(2'd1, 8'h5A, ok); m_out = 8'h5A;
    chk("R2 ack", ok, 1'b1); chk("R3 output write", drive, 8'h5A);

    // R2 one strap bit off: no ack, nothing written
    bus_start(); send_byte(abyte(strap ^ 3'b001, 1'b0), a);
    chk("R2 mismatch nack", a, 1'b0);
    send_byte(8'h01, a); send_byte(8'h00, a); bus_stop();
    chk("R2 mismatch no write", drive, 8'h5A);

    // R4 input view is pins XOR polarity
    wr_reg(2'd2, 8'hF0, ok); m_pol = 8'hF0;
    pins = 8'h3C; wcyc(4);
    rd_reg(2'd0, v); chk("R4 input view", v, 8'hCC);

    // R5 write to input view ignored
    wr_reg(2'd0, 8'h00, ok);
    rd_reg(2'd0, v); chk("R5 input unchanged", v, 8'hCC);
    chk("R5 drive unchanged", drive, 8'h5A);
    chk("R5 dir unchanged", dir_in, 8'hFF);

    // R3/R9 multi-byte write keeps pointer; one pulse per data byte
    w0 = wr_cnt;
    bus_start(); send_byte(abyte(strap, 1'b0), a); send_byte(8'h01, a);
    send_byte(8'hA1, a); send_byte(8'hB2, a); chk("R3 second data ack", a, 1'b1);
    bus_stop(); m_out = 8'hB2;
    chk("R3 last byte wins", drive, 8'hB2);
    chk("R9 write pulses", wr_cnt - w0, 2);
    // R3 pointer persists into a plain read
    bus_start(); send_byte(abyte(strap, 1'b1), a); recv_byte(1'b0, v); bus_stop();
    chk("R3 pointer persists", v, 8'hB2);

    // R4/R9 multi-byte read, NACK releases SDA
    r0 = rd_cnt;
    bus_start(); send_byte(abyte(strap, 1'b0), a); send_byte(8'h03, a);
    bus_start(); send_byte(abyte(strap, 1'b1), a);
    recv_byte(1'b1, v); recv_byte(1'b0, v2);
    chk("R4 sda free after nack", sda_pull, 1'b0);
    bus_stop();
    chk("R4 first read", v, 8'hFF); chk("R4 repeat read", v2, 8'hFF);
    chk("R9 read pulses", rd_cnt - r0, 2);
    chk("R7 idle after stop", sda_pull, 1'b0);

    // R6 START in the middle of a byte drops it
    bus_start(); send_byte(abyte(strap, 1'b0), a); send_byte(8'h01, a);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_start(); send_byte(abyte(strap, 1'b0), a); send_byte(8'h03, a);
    send_byte(8'h0F, a); bus_stop(); m_dir = 8'h0F;
    chk("R6 aborted byte not written", drive, 8'hB2);
    chk("R6 restart works", dir_in, 8'h0F);

    // R8 short glitches on SCL then SDA
    gmode = 1; wr_reg(2'd1, 8'h96, ok); gmode = 0; m_out = 8'h96;
    chk("R8 scl glitch", drive, 8'h96);
    gmode = 2; wr_reg(2'd1, 8'hF7, ok); gmode = 0; m_out = 8'hF7;
    chk("R8 sda glitch", drive, 8'hF7);

    // random mix against the bench model
    for (int it = 0; it < 10; it++) begin
      logic [1:0] sel;
      logic [7:0] val;
      strap = 3'($urandom); pins = 8'($urandom);
      sel = 2'($urandom); val = 8'($urandom);
      gmode = int'($urandom % 3);
      wr_reg(sel, val, ok); wr_model(sel, val); gmode = 0;
      chk("R2 random ack", ok, 1'b1);
      rd_reg(sel, v); chk("R3 R4 random readback", v, rd_model(sel));
      chk("R3 random drive", drive, m_out);
    end

    report();
    $finish;
  end
endmodule